// File: doc/BRIEF.md
# Single-Instruction Subtract-and-Branch Core

This core executes exactly one kind of instruction: it reads two byte operands from memory, subtracts them, writes the difference back over one of them, and jumps to a target address when the difference is negative. Data is 8 bits wide and addresses are 16 bits wide. Every address therefore has to be gathered from two byte reads. An instruction is six bytes in memory, in this order: B address high, B address low, A address high, A address low, target high, target low.

The core drives one memory port. Read data is expected in the same cycle the address is shown, and writes take effect on the clock edge. Two addresses are decoded inside the core. A read of `SW_ADDR` (default 0xFFFE) returns the switch input. A write to `LED_ADDR` (default 0xFFFF) loads the LED output register and is not sent to memory. An external loader can request the memory bus with `bus_req`. The core grants it only between instructions and keeps its memory outputs at zero while the grant is held.

The sequencer states are named by step. `ST_BHI` reads the B address high byte and `ST_BLO` reads the low byte. `ST_BRD` reads operand B. `ST_AHI`, `ST_ALO` and `ST_ARD` do the same for operand A. `ST_WR` writes the difference. `ST_THI` reads the target high byte and `ST_TLO` reads the target low byte and decides the new PC. `ST_HOLD` is the granted-bus state. The transitions run through the steps in order, one per cycle. `ST_TLO` goes to `ST_HOLD` when `bus_req` is high and to `ST_BHI` otherwise. `ST_HOLD` stays put while `bus_req` is high and goes to `ST_BHI` when it drops.

Top module: `sbn_core`

## Requirements
- R1: While reset is low and directly after it, the core shows address 0x0000 and does not write. The grant output is 0 and the LED output is 0x00.
- R2: An instruction fetched at PC takes nine cycles. The addresses shown are PC, PC+1, B address, PC+2, PC+3, A address, A address, PC+4 and PC+5, in that order.
- R3: The value written is (A − B) mod 256, sent to the A address. The write strobe is high only in the seventh cycle of the instruction.
- R4: When bit 7 of the difference is 1, the next instruction is fetched at the 16-bit target (high byte first in memory).
- R5: When bit 7 of the difference is 0, the next instruction is fetched at PC+6.
- R6: A read of address 0xFFFE returns the switch input in place of memory data.
- R7: A write to address 0xFFFF loads the LED output with the difference and keeps the memory write strobe low. The LED output changes at no other time.
- R8: A bus request is granted only after the ninth cycle of an instruction. While the grant is high, address, write data and write strobe are all zero.
- R9: When the request drops, the grant falls one cycle later. The core then resumes at the first step with the PC it had before the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as the address |
| mem_we | output | 1 | Memory write strobe |
| bus_req | input | 1 | External loader asks for the memory bus |
| bus_gnt | output | 1 | Memory bus handed to the loader |
| sw_in | input | 8 | Switch input, read at 0xFFFE |
| led_out | output | 8 | LED output register, written at 0xFFFF |

## Verification
The assertions check several properties on every cycle:
- writes are single-cycle and happen only in the write step;
- the operand-A read is always followed by the write step;
- the LED register changes only after a write step;
- the grant rises only after the last step and falls back into the first step;
- the memory outputs stay zero during a grant.

The arithmetic can only be shown by the bench's scenarios. These include a sweep over operand pairs, the branch choice for both signs, the exact nine-address pattern, the switch read, the LED write and the PC preserved across a grant.

// File: rtl/sbn_pkg.sv
package sbn_pkg;
    parameter int DW = 8;
    localparam int AW = 2 * DW;

    typedef enum logic [3:0] {
        ST_BHI, ST_BLO, ST_BRD,
        ST_AHI, ST_ALO, ST_ARD,
        ST_WR,  ST_THI, ST_TLO,
        ST_HOLD
    } step_e;

    typedef struct packed {
        logic addr_pc;
        logic addr_mar;
        logic pc_inc;
        logic mar_hi;
        logic mar_lo;
        logic ld_b;
        logic ld_a;
        logic wr;
        logic tgt_hi;
        logic tgt_lo;
        logic gnt;
    } ctl_t;
endpackage

// File: rtl/sbn_seq.sv
module sbn_seq
    import sbn_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bus_req,
    output step_e state,
    output ctl_t  ctl
);
    step_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_BHI;
        else        state <= nxt;
    end

    always_comb begin
        nxt = ST_BHI;
        ctl = '0;
        unique case (state)
            ST_BHI:  begin nxt = ST_BLO; ctl.addr_pc = 1'b1; ctl.pc_inc = 1'b1; ctl.mar_hi = 1'b1; end
            ST_BLO:  begin nxt = ST_BRD; ctl.addr_pc = 1'b1; ctl.pc_inc = 1'b1; ctl.mar_lo = 1'b1; end
            ST_BRD:  begin nxt = ST_AHI; ctl.addr_mar = 1'b1; ctl.ld_b = 1'b1; end
            ST_AHI:  begin nxt = ST_ALO; ctl.addr_pc = 1'b1; ctl.pc_inc = 1'b1; ctl.mar_hi = 1'b1; end
            ST_ALO:  begin nxt = ST_ARD; ctl.addr_pc = 1'b1; ctl.pc_inc = 1'b1; ctl.mar_lo = 1'b1; end
            ST_ARD:  begin nxt = ST_WR;  ctl.addr_mar = 1'b1; ctl.ld_a = 1'b1; end
            ST_WR:   begin nxt = ST_THI; ctl.addr_mar = 1'b1; ctl.wr = 1'b1; end
            ST_THI:  begin nxt = ST_TLO; ctl.addr_pc = 1'b1; ctl.pc_inc = 1'b1; ctl.tgt_hi = 1'b1; end
            ST_TLO:  begin nxt = bus_req ? ST_HOLD : ST_BHI; ctl.addr_pc = 1'b1; ctl.tgt_lo = 1'b1; end
            ST_HOLD: begin nxt = bus_req ? ST_HOLD : ST_BHI; ctl.gnt = 1'b1; end
            default: begin nxt = ST_BHI; end
        endcase
    end
endmodule

// File: rtl/sbn_datapath.sv
module sbn_datapath
    import sbn_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl,
    input  logic [DW-1:0] rd,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);
    logic [AW-1:0] pc, mar;
    logic [DW-1:0] opa, opb, tgt_hi, diff;
    logic          neg;

    assign diff = opa - opb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0; mar <= '0; opa <= '0; opb <= '0; tgt_hi <= '0; neg <= 1'b0;
        end else begin
            if (ctl.mar_hi) mar <= {rd, mar[DW-1:0]};
            if (ctl.mar_lo) mar <= {mar[AW-1:DW], rd};
            if (ctl.ld_b)   opb <= rd;
            if (ctl.ld_a)   opa <= rd;
            if (ctl.wr)     neg <= diff[DW-1];
            if (ctl.tgt_hi) tgt_hi <= rd;
            if (ctl.tgt_lo)      pc <= neg ? {tgt_hi, rd} : pc + 1'b1;
            else if (ctl.pc_inc) pc <= pc + 1'b1;
        end
    end

    always_comb begin
        addr = '0;
        if (ctl.addr_pc)       addr = pc;
        else if (ctl.addr_mar) addr = mar;
        wdata = ctl.wr ? diff : '0;
    end
endmodule

// File: rtl/sbn_io.sv
module sbn_io
    import sbn_pkg::*;
#(
    parameter logic [AW-1:0] SW_ADDR  = 16'hFFFE,
    parameter logic [AW-1:0] LED_ADDR = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] sw_in,
    output logic [DW-1:0] rd,
    output logic          mem_we,
    output logic [DW-1:0] led_out
);
    logic hit_led;

    assign hit_led = (addr == LED_ADDR);
    assign rd      = (addr == SW_ADDR) ? sw_in : mem_rdata;
    assign mem_we  = wr && !hit_led;

    always_ff @(posedge clk) begin
        if (!rst_n)             led_out <= '0;
        else if (wr && hit_led) led_out <= wdata;
    end
endmodule

// File: rtl/sbn_core.sv
module sbn_core
    import sbn_pkg::*;
#(
    parameter logic [AW-1:0] SW_ADDR  = 16'hFFFE,
    parameter logic [AW-1:0] LED_ADDR = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    input  logic          bus_req,
    output logic          bus_gnt,
    input  logic [DW-1:0] sw_in,
    output logic [DW-1:0] led_out
);
    step_e         state;
    ctl_t          ctl;
    logic [DW-1:0] rd;

    sbn_seq u_seq (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .state(state), .ctl(ctl)
    );

    sbn_datapath u_dp (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .rd(rd),
        .addr(mem_addr), .wdata(mem_wdata)
    );

    sbn_io #(.SW_ADDR(SW_ADDR), .LED_ADDR(LED_ADDR)) u_io (
        .clk(clk), .rst_n(rst_n), .addr(mem_addr), .wr(ctl.wr), .wdata(mem_wdata),
        .mem_rdata(mem_rdata), .sw_in(sw_in), .rd(rd), .mem_we(mem_we), .led_out(led_out)
    );

    assign bus_gnt = ctl.gnt;
endmodule

// File: rtl/sbn_core_chk.sv
module sbn_core_chk
    import sbn_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input step_e         state,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          bus_gnt,
    input logic [DW-1:0] led_out
);
    a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r3_write_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> state == ST_WR);

    a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ARD |=> state == ST_WR);

    a_r7_led_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led_out) |-> $past(state) == ST_WR);

    a_r8_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> (!mem_we && mem_addr == '0 && mem_wdata == '0));

    a_r8_grant_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_gnt) |-> $past(state) == ST_TLO);

    a_r9_resume_first_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_gnt) |-> state == ST_BHI);
endmodule

bind sbn_core sbn_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .bus_gnt(bus_gnt), .led_out(led_out)
);

// File: tb/tb_sbn_core.sv
module tb_sbn_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_we, bus_req = 1'b0, bus_gnt;
    logic [7:0]  sw_in = 8'h00, led_out;
    logic        lw_en = 1'b0;
    logic [11:0] lw_addr = '0;
    logic [7:0]  lw_data = '0;
    logic [7:0]  mem [0:4095];
    int n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    sbn_core dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .sw_in(sw_in), .led_out(led_out)
    );

    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) begin
        if (lw_en)       mem[lw_addr] <= lw_data;
        else if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int a, input int d);
        lw_en = 1'b1; lw_addr = a[11:0]; lw_data = d[7:0];
        @(negedge clk);
        lw_en = 1'b0;
    endtask

    task automatic put_instr(input int base, input int ba, input int aa, input int t);
        load(base,     ba >> 8); load(base + 1, ba & 255);
        load(base + 2, aa >> 8); load(base + 3, aa & 255);
        load(base + 4, t >> 8);  load(base + 5, t & 255);
    endtask

    task automatic run_pair(input int a, input int b);
        int d, nx;
        rst_n = 1'b0;
        put_instr(0, 16'h0100, 16'h0101, 16'h0040);
        load(16'h100, b); load(16'h101, a);
        rst_n = 1'b1;
        edges(9);
        d  = (a - b) & 255;
        nx = (d & 128) ? 16'h0040 : 6;
        chk(mem[12'h101] == d[7:0], "R3 difference", mem[12'h101], d);
        if (d & 128) chk(mem_addr == nx[15:0], "R4 branch taken", mem_addr, nx);
        else         chk(mem_addr == nx[15:0], "R5 fall through", mem_addr, nx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        int exp_a [9];
        @(negedge clk);
        // R1: reset state
        chk(mem_addr == 16'h0000, "R1 reset address", mem_addr, 0);
        chk(mem_we == 1'b0, "R1 reset write", mem_we, 0);
        chk(bus_gnt == 1'b0, "R1 reset grant", bus_gnt, 0);
        chk(led_out == 8'h00, "R1 reset led", led_out, 0);

        // R2: address pattern of one instruction
        put_instr(0, 16'h0110, 16'h0111, 16'h0080);
        load(16'h110, 5); load(16'h111, 9);
        exp_a = '{0, 1, 16'h110, 2, 3, 16'h111, 16'h111, 4, 5};
        rst_n = 1'b1;
        for (int i = 0; i < 9; i++) begin
            chk(mem_addr == exp_a[i][15:0], "R2 address order", mem_addr, exp_a[i]);
            chk(mem_we == (i == 6), "R3 write step", mem_we, (i == 6));
            @(negedge clk);
        end
        chk(mem_addr == 16'h0006, "R5 next at PC+6", mem_addr, 6);

        // R3 R4 R5: sweep of operand pairs
        for (int a = 0; a < 256; a += 5)
            for (int b = 0; b < 256; b += 7)
                run_pair(a, b);
        run_pair(0, 1); run_pair(128, 0); run_pair(0, 128);
        run_pair(127, 255); run_pair(255, 255); run_pair(127, 0);

        // R6: switch read
        rst_n = 1'b0;
        put_instr(0, 16'hFFFE, 16'h0101, 16'h0040);
        load(12'hFFE, 8'h99); load(16'h101, 8'h30);
        sw_in = 8'h22;
        rst_n = 1'b1;
        edges(9);
        chk(mem[12'h101] == 8'h0E, "R6 switch operand", mem[12'h101], 8'h0E);

        // R7: LED write
        rst_n = 1'b0;
        put_instr(0, 16'h0100, 16'hFFFF, 16'h0040);
        put_instr(6, 16'h0100, 16'h0101, 16'h0040);
        load(16'h100, 3); load(12'hFFF, 8'h50); load(16'h101, 8'h10);
        rst_n = 1'b1;
        edges(6);
        chk(mem_we == 1'b0, "R7 no memory write", mem_we, 0);
        edges(3);
        chk(led_out == 8'h4D, "R7 led value", led_out, 8'h4D);
        chk(mem[12'hFFF] == 8'h50, "R7 memory untouched", mem[12'hFFF], 8'h50);
        chk(mem_addr == 16'h0006, "R5 after led write", mem_addr, 6);
        edges(9);
        chk(led_out == 8'h4D, "R7 led holds", led_out, 8'h4D);
        chk(mem[12'h101] == 8'h0D, "R3 second instruction", mem[12'h101], 8'h0D);
        rst_n = 1'b0;
        @(negedge clk);
        chk(led_out == 8'h00, "R1 led cleared by reset", led_out, 0);

        // R8 R9: bus grant at instruction boundary
        put_instr(0, 16'h0100, 16'h0101, 16'h0040);
        load(16'h100, 2); load(16'h101, 9);
        rst_n = 1'b1;
        edges(3);
        bus_req = 1'b1;
        edges(5);
        chk(bus_gnt == 1'b0, "R8 no grant mid instruction", bus_gnt, 0);
        edges(1);
        chk(bus_gnt == 1'b1, "R8 grant at boundary", bus_gnt, 1);
        chk(mem_we == 1'b0 && mem_addr == 16'h0 && mem_wdata == 8'h0,
            "R8 outputs quiet", {mem_we, mem_addr, mem_wdata}, 0);
        load(16'h100, 8'hAA);
        edges(3);
        chk(bus_gnt == 1'b1, "R8 grant held", bus_gnt, 1);
        chk(mem[12'h101] == 8'h07, "R3 result before grant", mem[12'h101], 7);
        bus_req = 1'b0;
        edges(1);
        chk(bus_gnt == 1'b0, "R9 grant released", bus_gnt, 0);
        chk(mem_addr == 16'h0006, "R9 resume PC", mem_addr, 6);

        finish_run();
    end
endmodule